// File: doc/BRIEF.md
# Region-Expanding Prefetch Queue

This block sits between a prefetch address predictor and a cache, and turns predicted byte addresses into line-sized prefetch requests. An accepted candidate can take one of two forms. With the loop flag low, it becomes every line of the aligned four-line region that contains it. With the loop flag high, it becomes only the line that holds it. The lines are produced one per cycle and go into a small queue of line addresses. The queue drops duplicates and drops new entries when it is full. A demand miss reported by the cache adds the line just after the missed one. That next-line entry goes ahead of any region lines still waiting to be produced.

The cache has a single request port, and demand traffic shares it. The block drives that port. A demand request always owns it, and a queued prefetch is offered only when no demand is waiting. A prefetch leaves the queue only in the cycle its request is accepted through the valid/ready handshake. An upstream filter marks each candidate useful or useless. The block takes that verdict as an input bit and ignores useless candidates.

Top module: `prefetch_region_queue`

## Requirements
- R1: After reset the queue is empty, so `port_valid` is low while no demand is presented.
- R2: A candidate with `cand_valid`=1, `cand_useful`=1 and `loop_mode`=0, sampled at clock edge E, queues the four 64-byte lines of its 256-byte aligned region. The addresses are (addr & ~0xFF) + k*64 for k = 0,1,2,3, in ascending order, one line enqueued at each edge from E+1 through E+4 when nothing delays them.
- R3: A candidate accepted with `loop_mode`=1 queues only the line holding it (addr & ~0x3F).
- R4: A candidate with `cand_useful`=0 queues nothing.
- R5: A candidate presented while an earlier candidate's lines are still being produced is ignored.
- R6: A cycle with `miss_valid`=1 queues the line after the missed one, (miss_addr & ~0x3F) + 64, at that same edge.
- R7: When a next-line entry and a region line compete for the same edge, the next-line entry is enqueued. The region line is held, enqueued one edge later, and none is lost.
- R8: A line address already present in the queue is not enqueued again.
- R9: The queue holds 8 lines. A new line offered while it holds 8 is dropped, and older entries are kept.
- R10: While `dem_valid`=1, the port carries the demand: `port_addr`=`dem_addr`, `port_is_pf`=0, and `dem_ready` follows `port_ready`. No prefetch leaves the queue.
- R11: Prefetches leave in enqueue order. The head is presented with `port_is_pf`=1 and a stable line-aligned `port_addr` until an edge where `port_ready`=1, and it is removed only at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Candidate prefetch address present |
| cand_addr | input | 32 | Candidate byte address |
| cand_useful | input | 1 | Filter verdict; 0 discards the candidate |
| loop_mode | input | 1 | 1 = single-line mode, 0 = region expansion |
| miss_valid | input | 1 | A demand access missed this cycle |
| miss_addr | input | 32 | Byte address of the missed access |
| dem_valid | input | 1 | Demand request waiting for the port |
| dem_addr | input | 32 | Demand request address |
| dem_ready | output | 1 | Demand request accepted by the port |
| port_valid | output | 1 | Request valid on the cache port |
| port_addr | output | 32 | Request address on the cache port |
| port_is_pf | output | 1 | 1 when the port request is a prefetch |
| port_ready | input | 1 | Cache accepts the port request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is region expansion and next-line insertion, which compete for the queue's single write slot. The bench provokes this by raising a miss exactly two edges after a region candidate, so the miss lands on the second region line. It then expects the scoreboard order first line, next line, then the remaining three. The second pair is demand traffic and queue draining, which compete for the port. A demand is held for several cycles with `port_ready` high while prefetches are queued. Every cycle must show the demand address with no prefetch pop, and the full queued sequence must still come out afterwards.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int PFQ_ADDR_W       = 32;
    localparam int PFQ_LINE_BYTES   = 64;
    localparam int PFQ_REGION_LINES = 4;
    localparam int PFQ_DEPTH        = 8;

    // source of the line written into the queue in a given cycle
    typedef enum logic [1:0] {
        INS_NONE     = 2'd0,
        INS_NEXTLINE = 2'd1,
        INS_REGION   = 2'd2
    } ins_src_e;

    // owner of the shared cache port in a given cycle
    typedef enum logic [1:0] {
        OWN_IDLE     = 2'd0,
        OWN_DEMAND   = 2'd1,
        OWN_PREFETCH = 2'd2
    } port_own_e;
endpackage

// File: rtl/pfq_expander.sv
module pfq_expander #(
    parameter int LINE_W       = 26,
    parameter int REGION_LINES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_fire,
    input  logic [LINE_W-1:0] cand_line,
    input  logic              loop_mode,
    input  logic              stall,
    output logic              exp_valid,
    output logic [LINE_W-1:0] exp_line
);
    localparam int RG_W = $clog2(REGION_LINES);

    logic              busy;
    logic [LINE_W-1:0] cur;
    logic [RG_W-1:0]   left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
            left <= '0;
        end else if (!busy) begin
            if (cand_fire) begin
                busy <= 1'b1;
                if (loop_mode) begin
                    cur  <= cand_line;
                    left <= '0;
                end else begin
                    cur  <= {cand_line[LINE_W-1:RG_W], {RG_W{1'b0}}};
                    left <= RG_W'(REGION_LINES - 1);
                end
            end
        end else if (!stall) begin
            if (left == '0) begin
                busy <= 1'b0;
            end else begin
                cur  <= cur + LINE_W'(1);
                left <= left - RG_W'(1);
            end
        end
    end

    assign exp_valid = busy;
    assign exp_line  = cur;

    AST_EXP_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (exp_valid && !stall && left != '0) |=> (exp_valid && exp_line == $past(exp_line) + LINE_W'(1))); // R2
    AST_EXP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (exp_valid && stall) |=> (exp_valid && $stable(exp_line))); // R7
endmodule

// File: rtl/pfq_queue.sv
module pfq_queue #(
    parameter int LINE_W = 26,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [LINE_W-1:0] push_line,
    input  logic              pop,
    output logic              head_valid,
    output logic [LINE_W-1:0] head_line
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [LINE_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  slot_vld;
    logic [DEPTH-1:0]  hit_vec;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  cnt;
    logic              full, hit, do_push, do_pop;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = slot_vld[i] && (mem[i] == push_line);
    end

    assign hit     = |hit_vec;
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !full && !hit;
    assign do_pop  = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            cnt      <= '0;
            slot_vld <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr]      <= push_line;
                slot_vld[wr_ptr] <= 1'b1;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) begin
                slot_vld[rd_ptr] <= 1'b0;
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            end
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assign head_valid = (cnt != '0);
    assign head_line  = mem[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH)); // R9
    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (cnt == CNT_W'(DEPTH) && $stable(rd_ptr))); // R9
    AST_DUP_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && hit && !pop) |=> $stable(cnt)); // R8
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_valid); // R11
endmodule

// File: rtl/pfq_port_arb.sv
module pfq_port_arb
    import pfq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dem_valid,
    input  logic [ADDR_W-1:0] dem_addr,
    input  logic              pf_valid,
    input  logic [LINE_W-1:0] pf_line,
    input  logic              port_ready,
    output logic              port_valid,
    output logic [ADDR_W-1:0] port_addr,
    output logic              port_is_pf,
    output logic              dem_ready,
    output logic              pf_take
);
    localparam int OFS_W = ADDR_W - LINE_W;

    port_own_e owner;

    always_comb begin
        if (dem_valid)     owner = OWN_DEMAND;
        else if (pf_valid) owner = OWN_PREFETCH;
        else               owner = OWN_IDLE;
    end

    always_comb begin
        port_valid = (owner != OWN_IDLE);
        port_is_pf = (owner == OWN_PREFETCH);
        port_addr  = (owner == OWN_DEMAND) ? dem_addr : {pf_line, {OFS_W{1'b0}}};
        dem_ready  = port_ready;
        pf_take    = (owner == OWN_PREFETCH) && port_ready;
    end

    AST_DEMAND_WINS: assert property (@(posedge clk) disable iff (rst)
        dem_valid |-> !pf_take); // R10
    AST_PF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !dem_valid && !port_ready) |=> (pf_valid && $stable(pf_line))); // R11
endmodule

// File: rtl/prefetch_region_queue.sv
module prefetch_region_queue
    import pfq_pkg::*;
#(
    parameter int ADDR_W       = PFQ_ADDR_W,
    parameter int LINE_BYTES   = PFQ_LINE_BYTES,
    parameter int REGION_LINES = PFQ_REGION_LINES,
    parameter int DEPTH        = PFQ_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_valid,
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic              cand_useful,
    input  logic              loop_mode,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              dem_valid,
    input  logic [ADDR_W-1:0] dem_addr,
    output logic              dem_ready,
    output logic              port_valid,
    output logic [ADDR_W-1:0] port_addr,
    output logic              port_is_pf,
    input  logic              port_ready
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFS_W;

    logic [LINE_W-1:0] cand_line, miss_next, exp_line, ins_line, head_line;
    logic              cand_fire, exp_valid, head_valid, pf_take;
    ins_src_e          ins_src;

    assign cand_line = LINE_W'(cand_addr >> OFS_W);
    assign miss_next = LINE_W'(miss_addr >> OFS_W) + LINE_W'(1);
    assign cand_fire = cand_valid && cand_useful;

    always_comb begin
        if (miss_valid)     ins_src = INS_NEXTLINE;
        else if (exp_valid) ins_src = INS_REGION;
        else                ins_src = INS_NONE;
        ins_line = (ins_src == INS_NEXTLINE) ? miss_next : exp_line;
    end

    pfq_expander #(
        .LINE_W       (LINE_W),
        .REGION_LINES (REGION_LINES)
    ) u_exp (
        .clk       (clk),
        .rst       (rst),
        .cand_fire (cand_fire),
        .cand_line (cand_line),
        .loop_mode (loop_mode),
        .stall     (miss_valid),
        .exp_valid (exp_valid),
        .exp_line  (exp_line)
    );

    pfq_queue #(
        .LINE_W (LINE_W),
        .DEPTH  (DEPTH)
    ) u_q (
        .clk        (clk),
        .rst        (rst),
        .push       (ins_src != INS_NONE),
        .push_line  (ins_line),
        .pop        (pf_take),
        .head_valid (head_valid),
        .head_line  (head_line)
    );

    pfq_port_arb #(
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W)
    ) u_arb (
        .clk        (clk),
        .rst        (rst),
        .dem_valid  (dem_valid),
        .dem_addr   (dem_addr),
        .pf_valid   (head_valid),
        .pf_line    (head_line),
        .port_ready (port_ready),
        .port_valid (port_valid),
        .port_addr  (port_addr),
        .port_is_pf (port_is_pf),
        .dem_ready  (dem_ready),
        .pf_take    (pf_take)
    );

    AST_REGION_NEEDS_FILTER: assert property (@(posedge clk) disable iff (rst)
        (!exp_valid && cand_valid && !cand_useful) |=> !exp_valid); // R4
    AST_ALIGNED_PF: assert property (@(posedge clk) disable iff (rst)
        (port_valid && port_is_pf) |-> (port_addr[OFS_W-1:0] == '0)); // R11
endmodule

// File: tb/prefetch_region_queue_tb.sv
module prefetch_region_queue_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cand_valid = 1'b0, cand_useful = 1'b0, loop_mode = 1'b0;
    logic [31:0] cand_addr = '0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        dem_valid = 1'b0;
    logic [31:0] dem_addr = '0;
    logic        port_ready = 1'b0;
    logic        dem_ready, port_valid, port_is_pf;
    logic [31:0] port_addr;

    int checks = 0;
    int failures = 0;
    logic [31:0] expq[$];
    string       tagq[$];

    always #2 clk = ~clk; // 250 MHz

    prefetch_region_queue u_dut (
        .clk(clk), .rst(rst),
        .cand_valid(cand_valid), .cand_addr(cand_addr), .cand_useful(cand_useful),
        .loop_mode(loop_mode), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .dem_valid(dem_valid), .dem_addr(dem_addr), .dem_ready(dem_ready),
        .port_valid(port_valid), .port_addr(port_addr), .port_is_pf(port_is_pf),
        .port_ready(port_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_pf(input logic [31:0] a, input string tag);
        expq.push_back(a);
        tagq.push_back(tag);
    endtask

    task automatic send_cand(input logic [31:0] a, input logic useful, input logic lp);
        @(negedge clk);
        cand_valid = 1'b1; cand_addr = a; cand_useful = useful; loop_mode = lp;
        @(negedge clk);
        cand_valid = 1'b0; cand_useful = 1'b0; loop_mode = 1'b0;
    endtask

    task automatic send_miss(input logic [31:0] a);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = a;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        @(negedge clk);
        port_ready = 1'b1;
        for (int n = 0; n < 200 && expq.size() != 0; n++) @(posedge clk);
        @(negedge clk);
        port_ready = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(tag, {31'd0, port_valid}, 32'd0);
    endtask

    // monitor: compares each accepted prefetch and each demand cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && dem_valid) begin
                check("R10 demand addr", port_addr, dem_addr);
                check("R10 demand not pf", {31'd0, port_is_pf}, 32'd0);
                check("R10 dem_ready", {31'd0, dem_ready}, {31'd0, port_ready});
            end
            if (!rst && port_valid && port_is_pf && port_ready) begin
                if (expq.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R11 unexpected prefetch actual=%h expected=none", port_addr);
                end else begin
                    check(tagq.pop_front(), port_addr, expq.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset port_valid", {31'd0, port_valid}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R1 empty after reset", {31'd0, port_valid}, 32'd0);

        // R2 region expansion; R5 candidate while busy ignored
        expect_pf(32'h1234_5600, "R2 line0");
        expect_pf(32'h1234_5640, "R2 line1");
        expect_pf(32'h1234_5680, "R2 line2");
        expect_pf(32'h1234_56C0, "R2 line3");
        send_cand(32'h1234_5678, 1'b1, 1'b0);
        send_cand(32'h0000_AB00, 1'b1, 1'b0); // R5 arrives while busy
        repeat (6) @(negedge clk);
        send_cand(32'h9999_9999, 1'b0, 1'b0); // R4 useless
        repeat (3) @(negedge clk);
        send_cand(32'h1234_56C4, 1'b1, 1'b1); // R8 duplicate line
        repeat (3) @(negedge clk);
        #1;
        check("R11 head presented", port_addr, 32'h1234_5600);
        check("R11 head is pf", {31'd0, port_is_pf}, 32'd1);
        repeat (3) @(negedge clk);
        #1;
        check("R11 head held without ready", port_addr, 32'h1234_5600);
        drain("R4 R5 R8 nothing extra queued");

        // R3 loop mode, R6 next line
        expect_pf(32'h0000_1F40, "R3 loop single line");
        send_cand(32'h0000_1F48, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        expect_pf(32'h0000_4000, "R6 next line");
        send_miss(32'h0000_3FFF);
        repeat (2) @(negedge clk);
        drain("R3 R6 no extra lines");

        // R7 next-line collides with second region line
        expect_pf(32'h00A0_0100, "R7 region line0");
        expect_pf(32'h0050_0040, "R7 next line first");
        expect_pf(32'h00A0_0140, "R7 region line1 delayed");
        expect_pf(32'h00A0_0180, "R7 region line2");
        expect_pf(32'h00A0_01C0, "R7 region line3");
        @(negedge clk);
        cand_valid = 1'b1; cand_addr = 32'h00A0_0120; cand_useful = 1'b1; loop_mode = 1'b0;
        @(negedge clk);
        cand_valid = 1'b0; cand_useful = 1'b0;
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = 32'h0050_0010;
        @(negedge clk);
        miss_valid = 1'b0;
        repeat (6) @(negedge clk);
        drain("R7 no extra lines");

        // R9 full queue drops new lines
        for (int k = 0; k < 4; k++) expect_pf(32'h0000_1000 + k * 64, "R9 region A");
        for (int k = 0; k < 4; k++) expect_pf(32'h0000_2000 + k * 64, "R9 region B");
        send_cand(32'h0000_1010, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        send_cand(32'h0000_2030, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        send_cand(32'h0000_3000, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        send_miss(32'h0000_5000);
        repeat (2) @(negedge clk);
        drain("R9 dropped entries stay out");

        // R10 demand holds the port while prefetches wait
        for (int k = 0; k < 4; k++) expect_pf(32'h0000_7000 + k * 64, "R10 prefetch after demand");
        send_cand(32'h0000_7000, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        dem_valid = 1'b1; dem_addr = 32'hDEAD_BEE0; port_ready = 1'b1;
        repeat (5) @(negedge clk);
        dem_valid = 1'b0; port_ready = 1'b0;
        check("R10 queue untouched by demand", expq.size(), 32'd4);
        drain("R10 no extra lines");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule